// File: doc/BRIEF.md
# Predicated Deinterleaving Pair-Load Unit

This block carries out a vector load of two-word structures. Memory holds 32-bit words in pairs; the unit fetches each pair and sends the first word to one destination vector and the second word to a second destination vector, which is the next register after the first. A per-lane predicate mask decides which pairs are fetched. A lane whose predicate bit is clear issues no memory traffic, can never fault, and yields zero in both destination elements.

A command gives a base byte address, a 4-bit signed immediate and the predicate mask, together with a destination register index n. The immediate is scaled by twice the vector length in bytes, because one immediate step covers the two-register footprint of the load. The unit then walks the active lanes from lowest to highest over a word-wide read port with valid/ready handshakes on request and response and one request in flight at a time. It finishes with a one-cycle done pulse that carries both vectors for registers n and n+1, or a fault flag and the faulting lane when memory reports an error. The vector length is a synthesis parameter from 128 to 2048 bits, giving 4 to 64 lanes.

Top module: `pairld_unit`

## Requirements
- R1: For active lane i, the word at start+8i is placed in element i of `wb_vec_lo` and the word at start+8i+4 in element i of `wb_vec_hi`; element i occupies bits [32i+31:32i].
- R2: The start address is `cmd_base` plus the sign-extended `cmd_imm` times VL_BITS/4 bytes, computed modulo 2^ADDR_W (VL_BITS=256 gives a step of 64 bytes).
- R3: Active lanes are requested in ascending order, first word before second; a request holds its address until accepted, and no new request is raised until the previous response has been accepted.
- R4: A lane whose predicate bit is 0 issues no memory request, and both of its destination elements are delivered as zero.
- R5: A fault indication attached to an address belonging to an inactive lane has no effect, since that address is never requested; the command completes without fault.
- R6: A response with the fault bit set ends the command: no further request is issued, the next cycle shows `wb_done` and `wb_fault` high with `wb_fault_lane` naming the lane, and `wb_we` stays low.
- R7: An all-zero predicate raises `wb_done` in the cycle after acceptance with no memory traffic, `wb_we` high and both vectors zero.
- R8: `cmd_ready` is high only while idle and a command is accepted only then; `busy` is high from acceptance through the done cycle; `wb_done` is a one-cycle pulse.
- R9: On done, `wb_dst` reports the register index n given with the command; the write covers registers n and n+1.
- R10: After reset the unit is idle: `busy` and `wb_done` low, `cmd_ready` high, no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit idle and able to take a command |
| cmd_base | input | ADDR_W | Base byte address |
| cmd_imm | input | 4 | Signed immediate, scaled by twice the vector byte length |
| cmd_pred | input | LANES | Predicate mask, bit i governs lane i |
| cmd_dst | input | REG_W | Index n of the first destination register |
| mem_req_valid | output | 1 | Read request present |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | ADDR_W | Word byte address to read |
| mem_rsp_valid | input | 1 | Read response present |
| mem_rsp_ready | output | 1 | Unit takes the response |
| mem_rsp_data | input | 32 | Read data |
| mem_rsp_fault | input | 1 | Read failed |
| busy | output | 1 | Command in progress |
| wb_done | output | 1 | One-cycle completion pulse |
| wb_we | output | 1 | Write both destination registers |
| wb_fault | output | 1 | Command ended on a fault |
| wb_fault_lane | output | LANE_W | Lane whose read faulted |
| wb_dst | output | REG_W | Index n of the first destination register |
| wb_vec_lo | output | VL_BITS | Data for register n |
| wb_vec_hi | output | VL_BITS | Data for register n+1 |

## Verification
The hardest situation to reach is a fault that arrives part-way through a sparse predicate, where some lanes have already filled and later active lanes must never be requested. The bench's memory model faults on one chosen address, and the stimulus places that address on the second word of an active lane in the middle of the mask, then on an inactive lane of the same mask, so that both the early stop and the immunity of skipped lanes are seen in the request log. The request-ready line stalls on a repeating pattern, so requests are held across stalls throughout.

// File: rtl/pairld_pkg.sv
package pairld_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_RSP  = 2'd2,
        ST_DONE = 2'd3
    } pairld_state_e;

    localparam int unsigned WORD_W = 32;

endpackage

// File: rtl/pairld_addr.sv
module pairld_addr #(
    parameter int unsigned VL_BITS = 256,
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned LANE_W  = 3
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [3:0]        imm_i,
    input  logic [ADDR_W-1:0] start_i,
    input  logic [LANE_W-1:0] lane_i,
    input  logic              second_i,
    output logic [ADDR_W-1:0] start_o,
    output logic [ADDR_W-1:0] req_addr_o
);
    // one immediate step spans two registers of VL_BITS/8 bytes each
    localparam int unsigned STEP_SH = $clog2(VL_BITS / 4);

    logic [ADDR_W-1:0] imm_ext;
    logic [ADDR_W-1:0] lane_off;

    always_comb begin
        imm_ext    = {{(ADDR_W-4){imm_i[3]}}, imm_i};
        start_o    = base_i + (imm_ext << STEP_SH);
        lane_off   = ADDR_W'({lane_i, second_i, 2'b00});
        req_addr_o = start_i + lane_off;
    end
endmodule

// File: rtl/pairld_pick.sv
module pairld_pick #(
    parameter int unsigned LANES  = 8,
    parameter int unsigned LANE_W = 3
) (
    input  logic [LANES-1:0]  pend_i,
    output logic [LANES-1:0]  grant_o,
    output logic [LANE_W-1:0] lane_o,
    output logic              any_o
);
    logic [LANES:0] seen;

    assign seen[0] = 1'b0;

    for (genvar g = 0; g < LANES; g++) begin : g_chain
        assign seen[g+1]  = seen[g] | pend_i[g];
        assign grant_o[g] = pend_i[g] & ~seen[g];
    end

    assign any_o = seen[LANES];

    always_comb begin
        lane_o = '0;
        for (int i = 0; i < LANES; i++) begin
            if (grant_o[i]) lane_o = lane_o | LANE_W'(i);
        end
    end
endmodule

// File: rtl/pairld_deint.sv
module pairld_deint #(
    parameter int unsigned LANES  = 8,
    parameter int unsigned LANE_W = 3
) (
    input  logic [LANES*32-1:0] lo_i,
    input  logic [LANES*32-1:0] hi_i,
    input  logic [LANE_W-1:0]   lane_i,
    input  logic                second_i,
    input  logic                we_i,
    input  logic [31:0]         data_i,
    output logic [LANES*32-1:0] lo_o,
    output logic [LANES*32-1:0] hi_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic hit;
        assign hit = we_i && (lane_i == LANE_W'(g));
        assign lo_o[g*32 +: 32] = (hit && !second_i) ? data_i : lo_i[g*32 +: 32];
        assign hi_o[g*32 +: 32] = (hit &&  second_i) ? data_i : hi_i[g*32 +: 32];
    end
endmodule

// File: rtl/pairld_unit.sv
module pairld_unit
    import pairld_pkg::*;
#(
    parameter int unsigned VL_BITS = 256,
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned REG_W   = 5,
    localparam int unsigned LANES  = VL_BITS / WORD_W,
    localparam int unsigned LANE_W = $clog2(LANES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [ADDR_W-1:0]  cmd_base,
    input  logic [3:0]         cmd_imm,
    input  logic [LANES-1:0]   cmd_pred,
    input  logic [REG_W-1:0]   cmd_dst,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [ADDR_W-1:0]  mem_req_addr,
    input  logic               mem_rsp_valid,
    output logic               mem_rsp_ready,
    input  logic [31:0]        mem_rsp_data,
    input  logic               mem_rsp_fault,
    output logic               busy,
    output logic               wb_done,
    output logic               wb_we,
    output logic               wb_fault,
    output logic [LANE_W-1:0]  wb_fault_lane,
    output logic [REG_W-1:0]   wb_dst,
    output logic [VL_BITS-1:0] wb_vec_lo,
    output logic [VL_BITS-1:0] wb_vec_hi
);
    typedef struct packed {
        pairld_state_e      st;
        logic [LANES-1:0]   pend;
        logic               second;
        logic [ADDR_W-1:0]  start;
        logic [REG_W-1:0]   dst;
        logic               fault;
        logic [LANE_W-1:0]  flane;
        logic [VL_BITS-1:0] lo;
        logic [VL_BITS-1:0] hi;
    } unit_regs_t;

    unit_regs_t r_d, r_q;

    logic [ADDR_W-1:0]  start_w;
    logic [LANES-1:0]   grant_w;
    logic [LANE_W-1:0]  lane_w;
    logic               any_w;
    logic               fill_we;
    logic [VL_BITS-1:0] lo_w, hi_w;

    pairld_addr #(.VL_BITS(VL_BITS), .ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_addr (
        .base_i    (cmd_base),
        .imm_i     (cmd_imm),
        .start_i   (r_q.start),
        .lane_i    (lane_w),
        .second_i  (r_q.second),
        .start_o   (start_w),
        .req_addr_o(mem_req_addr)
    );

    pairld_pick #(.LANES(LANES), .LANE_W(LANE_W)) u_pick (
        .pend_i (r_q.pend),
        .grant_o(grant_w),
        .lane_o (lane_w),
        .any_o  (any_w)
    );

    pairld_deint #(.LANES(LANES), .LANE_W(LANE_W)) u_deint (
        .lo_i    (r_q.lo),
        .hi_i    (r_q.hi),
        .lane_i  (lane_w),
        .second_i(r_q.second),
        .we_i    (fill_we),
        .data_i  (mem_rsp_data),
        .lo_o    (lo_w),
        .hi_o    (hi_w)
    );

    always_comb begin
        logic [LANES-1:0] rest;
        r_d           = r_q;
        mem_req_valid = 1'b0;
        mem_rsp_ready = 1'b0;
        fill_we       = 1'b0;
        rest          = r_q.pend & ~grant_w;
        unique case (r_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    r_d.pend   = cmd_pred;
                    r_d.second = 1'b0;
                    r_d.start  = start_w;
                    r_d.dst    = cmd_dst;
                    r_d.fault  = 1'b0;
                    r_d.flane  = '0;
                    r_d.lo     = '0;
                    r_d.hi     = '0;
                    r_d.st     = (cmd_pred == '0) ? ST_DONE : ST_REQ;
                end
            end
            ST_REQ: begin
                mem_req_valid = any_w;
                if (!any_w) begin
                    r_d.st = ST_DONE;
                end else if (mem_req_ready) begin
                    r_d.st = ST_RSP;
                end
            end
            ST_RSP: begin
                mem_rsp_ready = 1'b1;
                if (mem_rsp_valid) begin
                    if (mem_rsp_fault) begin
                        r_d.fault = 1'b1;
                        r_d.flane = lane_w;
                        r_d.st    = ST_DONE;
                    end else begin
                        fill_we = 1'b1;
                        r_d.lo  = lo_w;
                        r_d.hi  = hi_w;
                        if (r_q.second) begin
                            r_d.second = 1'b0;
                            r_d.pend   = rest;
                            r_d.st     = (rest == '0) ? ST_DONE : ST_REQ;
                        end else begin
                            r_d.second = 1'b1;
                            r_d.st     = ST_REQ;
                        end
                    end
                end
            end
            ST_DONE: begin
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_ready     = (r_q.st == ST_IDLE);
    assign busy          = (r_q.st != ST_IDLE);
    assign wb_done       = (r_q.st == ST_DONE);
    assign wb_we         = wb_done && !r_q.fault;
    assign wb_fault      = wb_done && r_q.fault;
    assign wb_fault_lane = r_q.flane;
    assign wb_dst        = r_q.dst;
    assign wb_vec_lo     = r_q.lo;
    assign wb_vec_hi     = r_q.hi;

    // R3: a stalled request keeps its address
    a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R3: only one request in flight
    a_r3_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

    // R6: a faulting response ends the command at once
    a_r6_fault_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rsp_valid && mem_rsp_ready && mem_rsp_fault) |=> (wb_done && wb_fault && !wb_we && !mem_req_valid));

    // R7: empty predicate completes in the next cycle
    a_r7_empty_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && (cmd_pred == '0)) |=> (wb_done && wb_we));

    // R8: done is a single-cycle pulse, returning to idle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wb_done |=> (!wb_done && cmd_ready && !busy));

    // R8: busy covers the done cycle
    a_r8_busy_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        wb_done |-> (busy && !cmd_ready));
endmodule

// File: tb/pairld_unit_bench.sv
module pairld_unit_bench;
    localparam int unsigned VLB = 256;
    localparam int unsigned NL  = VLB / 32;

    typedef struct packed {
        logic [31:0]   base;
        logic [3:0]    imm;
        logic [NL-1:0] pred;
        logic [4:0]    dst;
    } vec_t;

    localparam vec_t TAB [6] = '{
        '{base: 32'h0000_1000, imm: 4'h0, pred: 8'hFF, dst: 5'd2},
        '{base: 32'h0000_2000, imm: 4'h3, pred: 8'hA5, dst: 5'd7},
        '{base: 32'h0000_1000, imm: 4'h8, pred: 8'h81, dst: 5'd30},
        '{base: 32'h0001_0040, imm: 4'h7, pred: 8'h5A, dst: 5'd0},
        '{base: 32'hFFFF_FFC0, imm: 4'h1, pred: 8'h0F, dst: 5'd15},
        '{base: 32'h0000_3000, imm: 4'hF, pred: 8'h80, dst: 5'd9}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic cmd_ready;
    logic [31:0] cmd_base = '0;
    logic [3:0] cmd_imm = '0;
    logic [NL-1:0] cmd_pred = '0;
    logic [4:0] cmd_dst = '0;
    logic mem_req_valid;
    logic mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic mem_rsp_valid = 1'b0;
    logic mem_rsp_ready;
    logic [31:0] mem_rsp_data = '0;
    logic mem_rsp_fault = 1'b0;
    logic busy, wb_done, wb_we, wb_fault;
    logic [2:0] wb_fault_lane;
    logic [4:0] wb_dst;
    logic [VLB-1:0] wb_vec_lo, wb_vec_hi;

    int checks = 0;
    int errors = 0;
    int tick = 0;
    int req_cnt = 0;
    logic [31:0] req_log [128];
    logic [31:0] fault_addr = 32'hFFFF_FFFF;
    logic req_hs = 1'b0;
    logic rsp_hs = 1'b0;
    logic [31:0] req_a = '0;

    always #5 clk = ~clk;

    pairld_unit #(.VL_BITS(VLB), .ADDR_W(32), .REG_W(5)) u_pairld_unit (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_base(cmd_base),
        .cmd_imm(cmd_imm), .cmd_pred(cmd_pred), .cmd_dst(cmd_dst),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
        .mem_rsp_fault(mem_rsp_fault), .busy(busy), .wb_done(wb_done),
        .wb_we(wb_we), .wb_fault(wb_fault), .wb_fault_lane(wb_fault_lane),
        .wb_dst(wb_dst), .wb_vec_lo(wb_vec_lo), .wb_vec_hi(wb_vec_hi)
    );

    function automatic logic [31:0] mword(input logic [31:0] a);
        return a ^ 32'hC3A5_5A3C;
    endfunction

    function automatic logic [31:0] start_of(input logic [31:0] b, input logic [3:0] imm);
        logic [31:0] s;
        s = {{28{imm[3]}}, imm};
        return b + (s << 6);
    endfunction

    // memory model: handshakes decided at one falling edge take effect at the next rising edge
    always @(negedge clk) begin
        tick = tick + 1;
        if (rsp_hs) begin
            mem_rsp_valid = 1'b0;
            mem_rsp_fault = 1'b0;
        end
        if (req_hs) begin
            if (req_cnt < 128) req_log[req_cnt] = req_a;
            req_cnt = req_cnt + 1;
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = mword(req_a);
            mem_rsp_fault = (req_a == fault_addr);
        end
        mem_req_ready = (tick % 3) != 1;
        req_hs = mem_req_valid && mem_req_ready;
        req_a  = mem_req_addr;
        rsp_hs = mem_rsp_valid && mem_rsp_ready;
    end

    task automatic chk(input bit ok, input string tag, input logic [VLB-1:0] act, input logic [VLB-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [31:0] b, input logic [3:0] imm, input logic [NL-1:0] p,
                           input logic [4:0] d, input bit poke, output int cyc);
        req_cnt = 0;
        @(negedge clk);
        cmd_base = b; cmd_imm = imm; cmd_pred = p; cmd_dst = d; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        cyc = 0;
        while (!wb_done && cyc < 2000) begin
            if (cyc == 0) chk(busy == 1'b1, "R8 busy after accept", VLB'(busy), VLB'(1));
            if (poke && cyc == 2) begin
                chk(cmd_ready == 1'b0, "R8 not ready while busy", VLB'(cmd_ready), VLB'(0));
                cmd_pred = '0; cmd_dst = 5'd31; cmd_valid = 1'b1;
            end else begin
                cmd_valid = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        cmd_valid = 1'b0;
    endtask

    task automatic check_good(input logic [31:0] b, input logic [3:0] imm, input logic [NL-1:0] p,
                              input logic [4:0] d, input string tag);
        logic [31:0] s;
        logic [VLB-1:0] elo, ehi;
        int k;
        s = start_of(b, imm);
        elo = '0; ehi = '0; k = 0;
        chk(wb_done && wb_we && !wb_fault, {tag, " R6 clean done"},
            VLB'({wb_done, wb_we, wb_fault}), VLB'(3'b110));
        chk(wb_dst == d, {tag, " R9 dst index"}, VLB'(wb_dst), VLB'(d));
        for (int i = 0; i < NL; i++) begin
            if (p[i]) begin
                elo[i*32 +: 32] = mword(s + 32'(8*i));
                ehi[i*32 +: 32] = mword(s + 32'(8*i + 4));
                if (k + 1 < 128) begin
                    chk(req_log[k] == s + 32'(8*i), {tag, " R2 R3 first word addr"},
                        VLB'(req_log[k]), VLB'(s + 32'(8*i)));
                    chk(req_log[k+1] == s + 32'(8*i + 4), {tag, " R3 second word addr"},
                        VLB'(req_log[k+1]), VLB'(s + 32'(8*i + 4)));
                end
                k += 2;
            end
        end
        chk(req_cnt == k, {tag, " R4 request count"}, VLB'(req_cnt), VLB'(k));
        chk(wb_vec_lo == elo, {tag, " R1 R4 low vector"}, wb_vec_lo, elo);
        chk(wb_vec_hi == ehi, {tag, " R1 R4 high vector"}, wb_vec_hi, ehi);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(!busy && !wb_done && cmd_ready && !mem_req_valid, "R10 reset state",
            VLB'({busy, wb_done, cmd_ready, mem_req_valid}), VLB'(4'b0010));
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && cmd_ready && !mem_req_valid, "R10 idle after reset",
            VLB'({busy, cmd_ready, mem_req_valid}), VLB'(3'b010));

        // table of commands: R1 R2 R3 R4 R9
        for (int t = 0; t < 6; t++) begin
            run_cmd(TAB[t].base, TAB[t].imm, TAB[t].pred, TAB[t].dst, 1'b0, cyc);
            check_good(TAB[t].base, TAB[t].imm, TAB[t].pred, TAB[t].dst, $sformatf("tab%0d", t));
            chk(busy == 1'b1, "R8 busy in done cycle", VLB'(busy), VLB'(1));
            @(negedge clk);
            chk(!wb_done && !busy && cmd_ready, "R8 done is one pulse",
                VLB'({wb_done, busy, cmd_ready}), VLB'(3'b001));
        end

        // R7 empty predicate
        run_cmd(32'h0000_5000, 4'h2, 8'h00, 5'd4, 1'b0, cyc);
        chk(cyc == 0, "R7 done one cycle after accept", VLB'(cyc), VLB'(0));
        chk(req_cnt == 0, "R7 no memory traffic", VLB'(req_cnt), VLB'(0));
        chk(wb_we && wb_vec_lo == '0 && wb_vec_hi == '0, "R7 zero write",
            VLB'(wb_we), VLB'(1));

        // R6 fault on second word of active lane 4, pred lanes 0,2,4,5,7
        fault_addr = 32'h0000_4000 + 32'd36;
        run_cmd(32'h0000_4000, 4'h0, 8'hB5, 5'd12, 1'b0, cyc);
        chk(wb_done && wb_fault && !wb_we, "R6 fault reported no write",
            VLB'({wb_done, wb_fault, wb_we}), VLB'(3'b110));
        chk(wb_fault_lane == 3'd4, "R6 fault lane", VLB'(wb_fault_lane), VLB'(4));
        chk(req_cnt == 6, "R6 no requests after fault", VLB'(req_cnt), VLB'(6));
        repeat (4) @(negedge clk);
        chk(req_cnt == 6 && !busy, "R6 stays quiet after fault", VLB'(req_cnt), VLB'(6));

        // R5 fault address on inactive lane 1
        fault_addr = 32'h0000_4000 + 32'd8;
        run_cmd(32'h0000_4000, 4'h0, 8'hB5, 5'd12, 1'b0, cyc);
        check_good(32'h0000_4000, 4'h0, 8'hB5, 5'd12, "R5 inactive fault");
        fault_addr = 32'hFFFF_FFFF;

        // R8 command while busy is ignored
        run_cmd(32'h0000_6000, 4'h1, 8'h3C, 5'd20, 1'b1, cyc);
        check_good(32'h0000_6000, 4'h1, 8'h3C, 5'd20, "R8 busy command ignored");
        @(negedge clk);
        chk(!busy && !wb_done, "R8 no second command taken", VLB'({busy, wb_done}), VLB'(0));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule